// File: doc/BRIEF.md
# Dual-Length Serial Channel Loader with Status Readback

This block receives channel settings over a serial link and commits them to one of two parallel registers. A mode input selects the target: a 96-bit correction register (16 channels of 6 bits) or a 192-bit grayscale register (16 channels of 12 bits). The length of the shift chain follows the mode, and a rising edge on the latch input commits the chain contents. The serial output always shows the top bit of the active chain, so several copies can be chained, output to input.

After every grayscale commit, the shift chain is overwritten with a 192-bit status word. A host then clocks that word out: per-channel open flags, the thermal flag and a copy of the correction data. The copy comes either from the live correction register or from a retained store, which a write strobe fills from the correction register. The first grayscale latch after a correction commit does not take effect at once. It finishes on the following shift strobe, and the data bit of that strobe is discarded.

Everything runs on one system clock. The shift clock arrives as a one-cycle strobe that marks its rising edge. The latch input is a level, and the block detects its rising edge internally.

Top module: `chan_load_port`

## Requirements
- R1: After reset the shift chain, the correction register, the grayscale register and the retained store are all zero, and the serial output is 0.
- R2: With mode_corr low, each shift strobe moves the 192-bit chain up one place and takes sdata_in into bit 0. sdata_out shows bit 191, so a word sent MSB first comes out MSB first, 192 strobes later.
- R3: With mode_corr high, only chain bits 95:0 shift, and sdata_out shows bit 95.
- R4: A latch rising edge with mode_corr high copies chain bits 95:0 into the correction register (channel n in bits 6n+5:6n) and leaves the grayscale register unchanged.
- R5: A latch rising edge with mode_corr low and no correction commit pending copies all 192 chain bits into the grayscale register (channel n in bits 12n+11:12n).
- R6: The cycle that commits grayscale data also loads the status word into the chain. Bit 176+n holds open_flags[n], bit 175 holds thermal_flag, bits 167:72 hold the selected correction data, and every other bit is zero.
- R7: The correction field of the status word comes from the correction register when corr_sel is 1 and from the retained store when corr_sel is 0.
- R8: A nv_write pulse copies the correction register into the retained store.
- R9: The first grayscale latch edge after a correction commit leaves both the grayscale register and the chain unchanged. The next shift strobe performs the commit and the status load, and its data bit is discarded.
- R10: Only a rising edge of latch_in commits. Holding latch_in high while shifting causes no further commits.
- R11: A shift strobe in the same cycle as a latch rising edge is discarded. The latch acts on the chain contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata_in | input | 1 | Serial data bit |
| shift_stb | input | 1 | One-cycle strobe marking a shift-clock rising edge |
| latch_in | input | 1 | Latch level; its rising edge commits |
| mode_corr | input | 1 | 1 selects correction mode, 0 selects grayscale mode |
| corr_sel | input | 1 | Status correction source: 1 register, 0 retained store |
| nv_write | input | 1 | Copy the correction register into the retained store |
| open_flags | input | 16 | Per-channel open-load flags |
| thermal_flag | input | 1 | Over-temperature flag |
| sdata_out | output | 1 | Top bit of the active chain, for cascading |
| corr_vec | output | 96 | Correction register |
| gray_vec | output | 192 | Grayscale register |

## Verification
A shift strobe and a latch rising edge can fall in the same cycle. This is provoked directly: both are raised for one clock after a full grayscale word has been shifted in. The result is judged by comparing the grayscale register with the untouched word, and by clocking the status word back out to confirm that no shifted bit corrupted it. The deferred commit has a second collision to check. There, the shift strobe that follows the latch must commit the data and load the status word instead of shifting. The bench confirms that the grayscale register holds its old value until that strobe arrives.

// File: rtl/chan_load_pkg.sv
package chan_load_pkg;

  typedef enum logic {
    TGT_GRAY = 1'b0,
    TGT_CORR = 1'b1
  } load_target_e;

  // Status word field positions, computed from channel count and gray width
  function automatic int stat_therm_bit(input int ch, input int gw);
    return ch * gw - ch - 1;
  endfunction

  function automatic int stat_corr_hi(input int ch, input int gw);
    return ch * gw - ch - 9;
  endfunction

  function automatic int stat_corr_lo(input int ch, input int cw, input int gw);
    return stat_corr_hi(ch, gw) - ch * cw + 1;
  endfunction

endpackage

// File: rtl/chan_load_ctrl.sv
module chan_load_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_in,
  input  logic shift_stb,
  input  logic mode_corr,
  output logic latch_rise,
  output logic corr_commit,
  output logic gray_commit,
  output logic shift_go,
  output logic held_q
);
  logic latch_q;
  logic armed_q;
  logic gray_latch;
  logic finish;

  always_comb begin
    latch_rise  = latch_in & ~latch_q;
    gray_latch  = latch_rise & ~mode_corr;
    corr_commit = latch_rise & mode_corr;
    finish      = held_q & shift_stb & ~latch_rise;
    gray_commit = (gray_latch & ~armed_q) | finish;
    shift_go    = shift_stb & ~latch_rise & ~finish;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      armed_q <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      latch_q <= latch_in;
      if (corr_commit)     armed_q <= 1'b1;
      else if (gray_latch) armed_q <= 1'b0;
      if (corr_commit)     held_q <= 1'b0;
      else if (gray_latch) held_q <= armed_q;
      else if (finish)     held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_load_shift.sv
module chan_load_shift #(
  parameter int unsigned GRAY_LEN = 192,
  parameter int unsigned CORR_LEN = 96
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_go,
  input  logic                sdin,
  input  logic                mode_corr,
  input  logic                status_load,
  input  logic [GRAY_LEN-1:0] status_word,
  output logic [GRAY_LEN-1:0] sr_q,
  output logic                sdout
);
  import chan_load_pkg::*;

  load_target_e tgt;
  assign tgt = mode_corr ? TGT_CORR : TGT_GRAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (status_load) begin
      sr_q <= status_word;
    end else if (shift_go) begin
      if (tgt == TGT_CORR) sr_q[CORR_LEN-1:0] <= {sr_q[CORR_LEN-2:0], sdin};
      else                 sr_q <= {sr_q[GRAY_LEN-2:0], sdin};
    end
  end

  assign sdout = (tgt == TGT_CORR) ? sr_q[CORR_LEN-1] : sr_q[GRAY_LEN-1];
endmodule

// File: rtl/chan_load_store.sv
module chan_load_store #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned CORR_W   = 6,
  parameter int unsigned GRAY_W   = 12,
  localparam int unsigned CL = CHANNELS * CORR_W,
  localparam int unsigned GL = CHANNELS * GRAY_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                corr_commit,
  input  logic                gray_commit,
  input  logic                nv_write,
  input  logic                corr_sel,
  input  logic [CHANNELS-1:0] open_flags,
  input  logic                thermal_flag,
  input  logic [GL-1:0]       sr_q,
  output logic [CL-1:0]       corr_q,
  output logic [GL-1:0]       gray_q,
  output logic [CL-1:0]       nv_q,
  output logic [GL-1:0]       status_word
);
  import chan_load_pkg::*;

  localparam int TH_BIT  = stat_therm_bit(CHANNELS, GRAY_W);
  localparam int CORR_HI = stat_corr_hi(CHANNELS, GRAY_W);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic [CORR_W-1:0] corr_ch;
    logic [GRAY_W-1:0] gray_ch;
    logic [CORR_W-1:0] nv_ch;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        corr_ch <= '0;
        gray_ch <= '0;
        nv_ch   <= '0;
      end else begin
        if (corr_commit) corr_ch <= sr_q[c*CORR_W +: CORR_W];
        if (gray_commit) gray_ch <= sr_q[c*GRAY_W +: GRAY_W];
        if (nv_write)    nv_ch   <= corr_ch;
      end
    end
    assign corr_q[c*CORR_W +: CORR_W] = corr_ch;
    assign gray_q[c*GRAY_W +: GRAY_W] = gray_ch;
    assign nv_q[c*CORR_W +: CORR_W]   = nv_ch;
  end

  always_comb begin
    status_word                    = '0;
    status_word[GL-1 -: CHANNELS]  = open_flags;
    status_word[TH_BIT]            = thermal_flag;
    status_word[CORR_HI -: CL]     = corr_sel ? corr_q : nv_q;
  end
endmodule

// File: rtl/chan_load_port.sv
module chan_load_port #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned CORR_W   = 6,
  parameter int unsigned GRAY_W   = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sdata_in,
  input  logic                         shift_stb,
  input  logic                         latch_in,
  input  logic                         mode_corr,
  input  logic                         corr_sel,
  input  logic                         nv_write,
  input  logic [CHANNELS-1:0]          open_flags,
  input  logic                         thermal_flag,
  output logic                         sdata_out,
  output logic [CHANNELS*CORR_W-1:0]   corr_vec,
  output logic [CHANNELS*GRAY_W-1:0]   gray_vec
);
  localparam int unsigned CL = CHANNELS * CORR_W;
  localparam int unsigned GL = CHANNELS * GRAY_W;

  logic          latch_rise;
  logic          corr_commit;
  logic          gray_commit;
  logic          shift_go;
  logic          held_q;
  logic [GL-1:0] sr_q;
  logic [GL-1:0] status_word;
  logic [CL-1:0] nv_q;

  chan_load_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_in    (latch_in),
    .shift_stb   (shift_stb),
    .mode_corr   (mode_corr),
    .latch_rise  (latch_rise),
    .corr_commit (corr_commit),
    .gray_commit (gray_commit),
    .shift_go    (shift_go),
    .held_q      (held_q)
  );

  chan_load_shift #(.GRAY_LEN(GL), .CORR_LEN(CL)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_go    (shift_go),
    .sdin        (sdata_in),
    .mode_corr   (mode_corr),
    .status_load (gray_commit),
    .status_word (status_word),
    .sr_q        (sr_q),
    .sdout       (sdata_out)
  );

  chan_load_store #(.CHANNELS(CHANNELS), .CORR_W(CORR_W), .GRAY_W(GRAY_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .corr_commit  (corr_commit),
    .gray_commit  (gray_commit),
    .nv_write     (nv_write),
    .corr_sel     (corr_sel),
    .open_flags   (open_flags),
    .thermal_flag (thermal_flag),
    .sr_q         (sr_q),
    .corr_q       (corr_vec),
    .gray_q       (gray_vec),
    .nv_q         (nv_q),
    .status_word  (status_word)
  );
endmodule

// File: rtl/chan_load_port_chk.sv
module chan_load_port_chk #(
  parameter int unsigned CHANNELS = 16,
  parameter int unsigned CORR_W   = 6,
  parameter int unsigned GRAY_W   = 12,
  localparam int unsigned CL = CHANNELS * CORR_W,
  localparam int unsigned GL = CHANNELS * GRAY_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sdata_in,
  input logic                shift_stb,
  input logic                mode_corr,
  input logic                nv_write,
  input logic                latch_rise,
  input logic                corr_commit,
  input logic                gray_commit,
  input logic                shift_go,
  input logic                held_q,
  input logic [GL-1:0]       sr_q,
  input logic [CL-1:0]       corr_vec,
  input logic [GL-1:0]       gray_vec,
  input logic [CL-1:0]       nv_q,
  input logic [CHANNELS-1:0] open_flags,
  input logic                thermal_flag
);
  import chan_load_pkg::*;
  localparam int TH_BIT = stat_therm_bit(CHANNELS, GRAY_W);

  p_gray_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_go && !mode_corr) |=> (sr_q[0] == $past(sdata_in)) && (sr_q[GL-1:1] == $past(sr_q[GL-2:0])));

  p_corr_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    corr_commit |=> corr_vec == $past(sr_q[CL-1:0]));

  p_gray_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gray_commit |=> gray_vec == $past(sr_q));

  p_status_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gray_commit |=> (sr_q[GL-1 -: CHANNELS] == $past(open_flags)) && (sr_q[TH_BIT] == $past(thermal_flag)));

  p_nv_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_write |=> nv_q == $past(corr_vec));

  p_defer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !shift_stb && !latch_rise) |=> $stable(gray_vec));

  p_edge_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(corr_vec));

  p_latch_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && mode_corr) |=> sr_q == $past(sr_q));
endmodule

bind chan_load_port chan_load_port_chk #(
  .CHANNELS(CHANNELS), .CORR_W(CORR_W), .GRAY_W(GRAY_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sdata_in     (sdata_in),
  .shift_stb    (shift_stb),
  .mode_corr    (mode_corr),
  .nv_write     (nv_write),
  .latch_rise   (latch_rise),
  .corr_commit  (corr_commit),
  .gray_commit  (gray_commit),
  .shift_go     (shift_go),
  .held_q       (held_q),
  .sr_q         (sr_q),
  .corr_vec     (corr_vec),
  .gray_vec     (gray_vec),
  .nv_q         (nv_q),
  .open_flags   (open_flags),
  .thermal_flag (thermal_flag)
);

// File: tb/chan_load_port_bench.sv
module chan_load_port_bench;
  localparam int CH = 16;
  localparam int CW = 6;
  localparam int GW = 12;
  localparam int CL = CH * CW;
  localparam int GL = CH * GW;

  logic          clk = 1'b0;
  logic          rst_n, sdata_in, shift_stb, latch_in, mode_corr, corr_sel, nv_write;
  logic [CH-1:0] open_flags;
  logic          thermal_flag;
  logic          sdata_out;
  logic [CL-1:0] corr_vec;
  logic [GL-1:0] gray_vec;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic [GL-1:0] ga, ga2, gb, gd, ge, word, cap;
  logic [CL-1:0] ca, cb, cc, ccap;

  always #4 clk = ~clk;

  chan_load_port u_chan_load_port (
    .clk(clk), .rst_n(rst_n), .sdata_in(sdata_in), .shift_stb(shift_stb),
    .latch_in(latch_in), .mode_corr(mode_corr), .corr_sel(corr_sel),
    .nv_write(nv_write), .open_flags(open_flags), .thermal_flag(thermal_flag),
    .sdata_out(sdata_out), .corr_vec(corr_vec), .gray_vec(gray_vec)
  );

  function automatic logic [GL-1:0] gpack(input int seed);
    logic [GL-1:0] v;
    for (int n = 0; n < CH; n++) v[n*GW +: GW] = GW'((n * seed * 37 + 7 * n * n + seed) % 4096);
    return v;
  endfunction

  function automatic logic [CL-1:0] cpack(input int seed);
    logic [CL-1:0] v;
    for (int n = 0; n < CH; n++) v[n*CW +: CW] = CW'((n * 11 + seed * 5 + 3) % 64);
    return v;
  endfunction

  function automatic logic [GL-1:0] mk_status(input logic [CH-1:0] op, input logic th, input logic [CL-1:0] cd);
    logic [GL-1:0] s;
    s = '0;
    for (int n = 0; n < CH; n++) s[176 + n] = op[n];
    s[175] = th;
    for (int b = 0; b < CL; b++) s[72 + b] = cd[b];
    return s;
  endfunction

  task automatic chk(input string tag, input logic [GL-1:0] act, input logic [GL-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_shift(input logic b);
    sdata_in = b; shift_stb = 1'b1;
    tick();
    shift_stb = 1'b0; sdata_in = 1'b0;
  endtask

  task automatic latch();
    latch_in = 1'b1; tick();
    latch_in = 1'b0; tick();
  endtask

  task automatic send_gray(input logic [GL-1:0] v);
    for (int i = GL - 1; i >= 0; i--) pulse_shift(v[i]);
  endtask

  task automatic send_gray_cap(input logic [GL-1:0] v, output logic [GL-1:0] c);
    for (int i = GL - 1; i >= 0; i--) begin c[i] = sdata_out; pulse_shift(v[i]); end
  endtask

  task automatic send_corr(input logic [CL-1:0] v);
    for (int i = CL - 1; i >= 0; i--) pulse_shift(v[i]);
  endtask

  task automatic send_corr_cap(input logic [CL-1:0] v, output logic [CL-1:0] c);
    for (int i = CL - 1; i >= 0; i--) begin c[i] = sdata_out; pulse_shift(v[i]); end
  endtask

  initial begin
    rst_n = 1'b0; sdata_in = 0; shift_stb = 0; latch_in = 0; mode_corr = 0;
    corr_sel = 0; nv_write = 0; open_flags = '0; thermal_flag = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R1 corr after reset", GL'(corr_vec), '0);
    chk("R1 gray after reset", gray_vec, '0);
    chk("R1 sdata_out after reset", GL'(sdata_out), '0);

    // Grayscale load with no pending correction commit
    open_flags = 16'hA5C3; thermal_flag = 1'b1; corr_sel = 1'b1; mode_corr = 1'b0;
    ga = gpack(3); send_gray(ga); latch();
    chk("R5 gray copy", gray_vec, ga);
    chk("R5 corr untouched", GL'(corr_vec), '0);
    send_gray_cap('0, word);
    chk("R6 status readback", word, mk_status(16'hA5C3, 1'b1, '0));

    // 192-bit chain: earlier word emerges MSB first
    ga2 = gpack(5); send_gray(ga2);
    send_gray_cap(gpack(7), cap);
    chk("R2 gray chain out", cap, ga2);

    // Correction mode: 96-bit chain
    mode_corr = 1'b1;
    ca = cpack(1); send_corr(ca);
    cb = cpack(2); send_corr_cap(cb, ccap);
    chk("R3 corr chain out", GL'(ccap), GL'(ca));
    latch();
    chk("R4 corr copy", GL'(corr_vec), GL'(cb));
    chk("R4 gray untouched", gray_vec, ga);
    nv_write = 1'b1; tick(); nv_write = 1'b0;
    cc = cpack(4); send_corr(cc); latch();
    chk("R4 second corr copy", GL'(corr_vec), GL'(cc));

    // First grayscale latch after a correction commit is deferred
    mode_corr = 1'b0; corr_sel = 1'b0; open_flags = 16'h0F01; thermal_flag = 1'b0;
    gb = gpack(9); send_gray(gb); latch();
    chk("R9 gray held after latch", gray_vec, ga);
    chk("R9 chain kept after latch", GL'(sdata_out), GL'(gb[GL-1]));
    pulse_shift(1'b1);
    chk("R9 commit on extra strobe", gray_vec, gb);
    send_gray_cap('0, word);
    chk("R7 R8 status from retained store", word, mk_status(16'h0F01, 1'b0, cb));

    // Shift strobe in the same cycle as the latch edge
    corr_sel = 1'b1;
    gd = gpack(13); send_gray(gd);
    latch_in = 1'b1; shift_stb = 1'b1; sdata_in = 1'b1; tick();
    latch_in = 1'b0; shift_stb = 1'b0; sdata_in = 1'b0; tick();
    chk("R11 gray not shifted", gray_vec, gd);
    send_gray_cap('0, word);
    chk("R11 R7 status from register", word, mk_status(16'h0F01, 1'b0, cc));

    // Latch level held high: no further commits
    ge = gpack(17); send_gray(ge);
    latch_in = 1'b1; tick();
    chk("R10 gray on edge", gray_vec, ge);
    for (int k = 0; k < 5; k++) pulse_shift(1'b1);
    tick();
    chk("R10 no commit while high", gray_vec, ge);
    chk("R10 corr unchanged", GL'(corr_vec), GL'(cc));
    latch_in = 1'b0; tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule